// File: doc/BRIEF.md
# Dual-Port RAM with Address-Contention Arbiter

This block is a clocked model of a true dual-port memory, 1K x 8 by default. Two independent ports, left and right, can reach every location. Each port has an address, an active-low chip enable, a read/write strobe (high for read, low for write), an active-low output enable, a write data bus, a registered read data bus and a data-valid flag. Both ports share one clock and one active-low reset.

When both ports are enabled on the same address, a three-state arbiter gives the location to one port and pulls the other port's active-low busy flag low. The port that arrived at least one clock earlier wins. If both arrive in the same cycle, the left port wins. A write from the losing port is thrown away. If the winning port writes the shared location, the loser's read output keeps the value it had before that write. It stays frozen until one of four release events occurs: the loser's busy flag returns high, its address changes, its chip enable changes, or its read/write strobe changes.

The arbiter has three states. ARB_FREE means nobody is busy. ARB_LEFT_WINS means the right port is busy. ARB_RIGHT_WINS means the left port is busy. Transitions:
- FREE goes to LEFT_WINS on a match where the left port arrived first, or on a same-cycle tie.
- FREE goes to RIGHT_WINS on a match where only the right port was already in place in the previous cycle.
- LEFT_WINS and RIGHT_WINS return to FREE in any cycle without a match.
- Otherwise the state holds.

Top module: `dpram_arb`

## Requirements
- R1: A port writes while its chip enable and read/write are both low. The location and data held in the last cycle of that overlap are stored in the cycle after the overlap ends. Data presented earlier in the same write is replaced.
- R2: With chip enable low, output enable low and read/write high in cycle c, after the next edge the port's data-out holds the word at its address and data-valid is 1. In any other case data-valid is 0 after the next edge.
- R3: Reset drives both busy flags high and both data-valid flags low. The two busy flags are never low together.
- R4: A match is both chip enables low with equal addresses. A match in cycle c pulls exactly one busy flag low after the next edge. The port whose enable and address were already in place in cycle c-1 wins, and the other port's busy flag goes low.
- R5: When both ports start matching in the same cycle, the left port wins and the right busy flag goes low.
- R6: In a cycle without a match (the addresses differ, or either chip enable is high), both busy flags are high after the next edge.
- R7: A write by a port that is the arbitration loser in any cycle of the write, or in the cycle it ends, leaves memory unchanged.
- R8: When the winner stores a word to the address the loser is reading, the loser's data-out keeps the older word. The loser's busy flag going high releases the hold, and the new word appears one edge after busy is high.
- R9: A change of the loser's address releases a held read output at the next edge, showing the word at the new address.
- R10: A toggle of the loser's chip enable releases a held read output. The current word appears once the read resumes.
- R11: A toggle of the loser's read/write strobe releases a held read output. The current word appears once the read resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_addr | input | AW | Left port address |
| l_cen | input | 1 | Left chip enable, active low |
| l_rwn | input | 1 | Left read (1) / write (0) strobe |
| l_oen | input | 1 | Left output enable, active low |
| l_din | input | DW | Left write data |
| l_dout | output | DW | Left registered read data |
| l_dvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_addr | input | AW | Right port address |
| r_cen | input | 1 | Right chip enable, active low |
| r_rwn | input | 1 | Right read (1) / write (0) strobe |
| r_oen | input | 1 | Right output enable, active low |
| r_din | input | DW | Right write data |
| r_dout | output | DW | Right registered read data |
| r_dvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
Storage is tried with all-zero, all-one and alternating bit patterns at the lowest, highest and mid addresses. Writes alternate between the ports so that a swapped port or a stuck data bit shows up. Arbitration is tried three ways, each telling apart a different priority rule:
- the right port arriving first,
- both ports arriving in the same cycle,
- a double write collision.

The four hold-release paths each run from the same frozen state, so each release event is shown to free the output on its own. A write attempt by the loser, made with a distinct data value, shows that the data was blocked rather than merely late.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_WINS  = 2'd1,
        ARB_RIGHT_WINS = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dpram_arb_fsm.sv
module dpram_arb_fsm
    import dpram_arb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic          r_en,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_lose,
    output logic          r_lose
);
    arb_state_e    state_q, state_d;
    logic          l_en_q, r_en_q;
    logic [AW-1:0] l_addr_q, r_addr_q;
    logic          match, l_old, r_old;

    assign match = l_en && r_en && (l_addr == r_addr);
    // a port counts as earlier when it was enabled on this address last cycle
    assign l_old = l_en_q && (l_addr_q == l_addr);
    assign r_old = r_en_q && (r_addr_q == r_addr);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (match) state_d = (r_old && !l_old) ? ARB_RIGHT_WINS : ARB_LEFT_WINS;
            end
            ARB_LEFT_WINS, ARB_RIGHT_WINS: begin
                if (!match) state_d = ARB_FREE;
            end
            default: state_d = ARB_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ARB_FREE;
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            state_q  <= state_d;
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    always_comb begin
        l_lose   = (state_q == ARB_RIGHT_WINS);
        r_lose   = (state_q == ARB_LEFT_WINS);
        l_busy_n = !l_lose;
        r_busy_n = !r_lose;
    end
endmodule

// File: rtl/dpram_arb_port.sv
module dpram_arb_port #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rwn,
    input  logic          oen,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic          lose,
    input  logic          peer_commit,
    input  logic [AW-1:0] peer_addr,
    input  logic [DW-1:0] rdata,
    output logic          commit,
    output logic [AW-1:0] waddr,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] dout,
    output logic          dvalid
);
    logic          wr_act, rd_act;
    logic          pend_q, poison_q;
    logic          hold_q, hold_eff, set_hold, release_ev;
    logic          en_q, rwn_q;
    logic [AW-1:0] addr_q;

    assign wr_act = en && !rwn;
    assign rd_act = en && rwn && !oen;
    assign commit = pend_q && !wr_act && !(poison_q || lose);

    // write capture: last address/data of the strobe overlap, blocked if lost
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q   <= 1'b0;
            poison_q <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
        end else if (wr_act) begin
            pend_q   <= 1'b1;
            poison_q <= (pend_q && poison_q) || lose;
            waddr    <= addr;
            wdata    <= din;
        end else begin
            pend_q   <= 1'b0;
            poison_q <= 1'b0;
        end
    end

    assign release_ev = !lose || (addr != addr_q) || (en != en_q) || (rwn != rwn_q);
    assign hold_eff   = hold_q && !release_ev;
    assign set_hold   = lose && rd_act && peer_commit && (peer_addr == addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            en_q   <= 1'b0;
            rwn_q  <= 1'b1;
            addr_q <= '0;
            dout   <= '0;
            dvalid <= 1'b0;
        end else begin
            hold_q <= set_hold || hold_eff;
            en_q   <= en;
            rwn_q  <= rwn;
            addr_q <= addr;
            dvalid <= rd_act;
            if (!hold_eff) dout <= rd_act ? rdata : '0;
        end
    end
endmodule

// File: rtl/dpram_arb_store.sv
module dpram_arb_store #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          l_we,
    input  logic [AW-1:0] l_waddr,
    input  logic [DW-1:0] l_wdata,
    input  logic          r_we,
    input  logic [AW-1:0] r_waddr,
    input  logic [DW-1:0] r_wdata,
    input  logic [AW-1:0] l_raddr,
    input  logic [AW-1:0] r_raddr,
    output logic [DW-1:0] l_rdata,
    output logic [DW-1:0] r_rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (l_we) mem[l_waddr] <= l_wdata;
        if (r_we) mem[r_waddr] <= r_wdata;
    end

    assign l_rdata = mem[l_raddr];
    assign r_rdata = mem[r_raddr];
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] l_addr,
    input  logic          l_cen,
    input  logic          l_rwn,
    input  logic          l_oen,
    input  logic [DW-1:0] l_din,
    output logic [DW-1:0] l_dout,
    output logic          l_dvalid,
    output logic          l_busy_n,
    input  logic [AW-1:0] r_addr,
    input  logic          r_cen,
    input  logic          r_rwn,
    input  logic          r_oen,
    input  logic [DW-1:0] r_din,
    output logic [DW-1:0] r_dout,
    output logic          r_dvalid,
    output logic          r_busy_n
);
    logic          l_lose, r_lose, l_commit, r_commit;
    logic [AW-1:0] l_waddr, r_waddr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

    dpram_arb_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .l_en(!l_cen), .r_en(!r_cen),
        .l_addr(l_addr), .r_addr(r_addr),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_lose(l_lose), .r_lose(r_lose)
    );

    dpram_arb_port #(.AW(AW), .DW(DW)) u_lport (
        .clk(clk), .rst_n(rst_n), .en(!l_cen), .rwn(l_rwn), .oen(l_oen),
        .addr(l_addr), .din(l_din), .lose(l_lose),
        .peer_commit(r_commit), .peer_addr(r_waddr), .rdata(l_rdata),
        .commit(l_commit), .waddr(l_waddr), .wdata(l_wdata),
        .dout(l_dout), .dvalid(l_dvalid)
    );

    dpram_arb_port #(.AW(AW), .DW(DW)) u_rport (
        .clk(clk), .rst_n(rst_n), .en(!r_cen), .rwn(r_rwn), .oen(r_oen),
        .addr(r_addr), .din(r_din), .lose(r_lose),
        .peer_commit(l_commit), .peer_addr(l_waddr), .rdata(r_rdata),
        .commit(r_commit), .waddr(r_waddr), .wdata(r_wdata),
        .dout(r_dout), .dvalid(r_dvalid)
    );

    dpram_arb_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk),
        .l_we(l_commit), .l_waddr(l_waddr), .l_wdata(l_wdata),
        .r_we(r_commit), .r_waddr(r_waddr), .r_wdata(r_wdata),
        .l_raddr(l_addr), .r_raddr(r_addr),
        .l_rdata(l_rdata), .r_rdata(r_rdata)
    );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] l_addr,
    input logic          l_cen,
    input logic          l_rwn,
    input logic          l_oen,
    input logic          l_dvalid,
    input logic          l_busy_n,
    input logic [AW-1:0] r_addr,
    input logic          r_cen,
    input logic          r_rwn,
    input logic          r_oen,
    input logic          r_dvalid,
    input logic          r_busy_n
);
    logic match;
    assign match = !l_cen && !r_cen && (l_addr == r_addr);

    a_r3_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        l_busy_n || r_busy_n);

    a_r4_match_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (l_busy_n != r_busy_n));

    a_r4_busy_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> $past(match));

    a_r6_mismatch_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> (l_busy_n && r_busy_n));

    a_r2_left_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (l_cen || l_oen || !l_rwn) |=> !l_dvalid);

    a_r2_right_valid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (r_cen || r_oen || !r_rwn) |=> !r_dvalid);
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW)) u_chk (.*);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_cen = 1'b1, r_cen = 1'b1;
    logic          l_rwn = 1'b1, r_rwn = 1'b1;
    logic          l_oen = 1'b0, r_oen = 1'b0;
    logic [DW-1:0] l_din = '0, r_din = '0;
    logic [DW-1:0] l_dout, r_dout;
    logic          l_dvalid, r_dvalid, l_busy_n, r_busy_n;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dpram_arb #(.AW(AW), .DW(DW)) u_dut (.*);

    // {address, data}; even entries written by left and read by right, odd the reverse
    localparam logic [AW+DW-1:0] VEC [0:7] = '{
        {10'd0,    8'h00}, {10'd1023, 8'hFF}, {10'h155, 8'hA5}, {10'h2AA, 8'h5A},
        {10'd1,    8'h01}, {10'd512,  8'h80}, {10'd77,  8'hC7}, {10'd1000, 8'h3E}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        l_cen = 1'b1; l_rwn = 1'b1; l_oen = 1'b0;
        r_cen = 1'b1; r_rwn = 1'b1; r_oen = 1'b0;
        step(); step();
    endtask

    task automatic wr(input bit right, input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (right) begin r_addr = a; r_din = d; r_cen = 1'b0; r_rwn = 1'b0; end
        else       begin l_addr = a; l_din = d; l_cen = 1'b0; l_rwn = 1'b0; end
        step();
        if (right) begin r_cen = 1'b1; r_rwn = 1'b1; end
        else       begin l_cen = 1'b1; l_rwn = 1'b1; end
        step();
    endtask

    task automatic rd(input bit right, input logic [AW-1:0] a, input logic [DW-1:0] exp,
                      input string req);
        if (right) begin r_addr = a; r_cen = 1'b0; r_rwn = 1'b1; r_oen = 1'b0; end
        else       begin l_addr = a; l_cen = 1'b0; l_rwn = 1'b1; l_oen = 1'b0; end
        step();
        chk(req, right ? r_dout : l_dout, exp);
        chk(req, right ? r_dvalid : l_dvalid, 1);
        if (right) r_cen = 1'b1; else l_cen = 1'b1;
        step();
    endtask

    // left arrives first and wins; right reads a; left stores newv, right stays frozen on oldv
    task automatic hold_setup(input logic [AW-1:0] a, input logic [DW-1:0] oldv,
                              input logic [DW-1:0] newv, input logic [DW-1:0] nb);
        wr(0, a, oldv);
        wr(0, a + 1, nb);
        l_addr = a; l_cen = 1'b0; l_rwn = 1'b1;
        step();
        r_addr = a; r_cen = 1'b0; r_rwn = 1'b1; r_oen = 1'b0;
        step();
        chk("R4 right loses to earlier left", r_busy_n, 0);
        chk("R8 right reads before store", r_dout, oldv);
        l_din = newv; l_rwn = 1'b0;
        step();
        l_rwn = 1'b1;
        step();
        step();
        chk("R8 loser output held after winner store", r_dout, oldv);
        chk("R8 winner sees new word", l_dout, newv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(); step();
        chk("R3 reset left busy high", l_busy_n, 1);
        chk("R3 reset right busy high", r_busy_n, 1);
        chk("R3 reset left valid low", l_dvalid, 0);
        chk("R3 reset right valid low", r_dvalid, 0);
        rst_n = 1'b1;
        step();

        // R1/R2 table walk across both ports
        for (int i = 0; i < 8; i++) begin
            wr(i[0], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
            rd(!i[0], VEC[i][AW+DW-1:DW], VEC[i][DW-1:0], "R1 R2 table readback");
        end

        // R2: output enable high gives no valid data
        l_addr = 10'd1; l_cen = 1'b0; l_oen = 1'b1;
        step();
        chk("R2 oen high valid low", l_dvalid, 0);
        idle();

        // R1: data changed during a multi-cycle write; last value kept
        l_addr = 10'd300; l_din = 8'h11; l_cen = 1'b0; l_rwn = 1'b0;
        step();
        l_din = 8'h22;
        step();
        chk("R1 valid low during write", l_dvalid, 0);
        l_cen = 1'b1; l_rwn = 1'b1;
        step();
        rd(1, 10'd300, 8'h22, "R1 last data of write stored");

        // R4 right first, then R6 address path
        r_addr = 10'd5; r_cen = 1'b0;
        step();
        l_addr = 10'd5; l_cen = 1'b0;
        step();
        chk("R4 earlier right wins, left busy", l_busy_n, 0);
        chk("R4 right not busy", r_busy_n, 1);
        l_addr = 10'd6;
        step();
        chk("R6 address mismatch releases left", l_busy_n, 1);
        chk("R6 address mismatch right high", r_busy_n, 1);
        idle();

        // R5 same-cycle arrival, then R6 chip-enable path
        l_addr = 10'd7; r_addr = 10'd7; l_cen = 1'b0; r_cen = 1'b0;
        step();
        chk("R5 tie gives right busy", r_busy_n, 0);
        chk("R5 tie left free", l_busy_n, 1);
        r_cen = 1'b1;
        step();
        chk("R6 cen high releases right", r_busy_n, 1);
        idle();

        // R7 double write collision on one address
        l_addr = 10'd9; r_addr = 10'd9; l_din = 8'hAA; r_din = 8'h55;
        l_cen = 1'b0; r_cen = 1'b0; l_rwn = 1'b0; r_rwn = 1'b0;
        step();
        chk("R5 collision right busy", r_busy_n, 0);
        l_cen = 1'b1; r_cen = 1'b1; l_rwn = 1'b1; r_rwn = 1'b1;
        step();
        idle();
        rd(0, 10'd9, 8'hAA, "R7 collision keeps winner data");

        // R7 losing port write attempt while busy
        wr(1, 10'd12, 8'h3C);
        r_addr = 10'd12; r_cen = 1'b0; r_rwn = 1'b1;
        step();
        l_addr = 10'd12; l_cen = 1'b0; l_rwn = 1'b1;
        step();
        chk("R7 left busy before write", l_busy_n, 0);
        l_din = 8'hC3; l_rwn = 1'b0;
        step();
        l_rwn = 1'b1;
        step();
        idle();
        rd(0, 10'd12, 8'h3C, "R7 blocked write left memory unchanged");

        // R8 release by busy going high
        hold_setup(10'd20, 8'h10, 8'h99, 8'h21);
        l_cen = 1'b1;
        step();
        chk("R8 busy high after winner leaves", r_busy_n, 1);
        chk("R8 still old until busy high seen", r_dout, 8'h10);
        step();
        chk("R8 new word after busy release", r_dout, 8'h99);
        idle();

        // R9 release by address change
        hold_setup(10'd30, 8'h31, 8'h32, 8'h33);
        r_addr = 10'd31;
        step();
        chk("R9 address change releases hold", r_dout, 8'h33);
        idle();

        // R10 release by chip-enable toggle
        hold_setup(10'd40, 8'h41, 8'h42, 8'h43);
        r_cen = 1'b1;
        step();
        r_cen = 1'b0;
        step();
        chk("R10 cen toggle releases hold", r_dout, 8'h42);
        chk("R10 valid after cen toggle", r_dvalid, 1);
        idle();

        // R11 release by read/write toggle, the loser's write attempt blocked
        hold_setup(10'd50, 8'h51, 8'h52, 8'h53);
        r_din = 8'hEE; r_rwn = 1'b0;
        step();
        r_rwn = 1'b1;
        step();
        chk("R11 rw toggle releases hold", r_dout, 8'h52);
        step();
        chk("R7 loser rw pulse not stored", r_dout, 8'h52);
        idle();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule